// File: doc/BRIEF.md
# Interrupt Offset Vector Register

This block holds three banks of sticky interrupt flags: buffer full, request lost and bus error. Each bank has one bit per channel slot. Slot number k is 2·n + s, where n is the channel pair and s is 0 for sub-channel A or 1 for sub-channel B. A per-slot map input sends every slot to one of two interrupt lines. For each line, the block builds a read-only offset word. That word names the type and the slot of the most urgent pending flag that is mapped to the line. The block also raises that line's interrupt output while anything is pending on it.

Software services an interrupt by reading the offset word of its line through a simple read port. When the read covers the byte that holds the slot field, it also clears the flag that is being reported. A debug input suppresses this side effect, so a debugger can look at the word without changing any state. Flags are set by single-cycle pulse inputs. The slot count and the encoder style (linear scan or binary tree) are parameters.

Top module: `irq_offset_vec`

## Requirements
- R1: The returned word has the type code in bits 9:8 and the slot number in bits 3:0. Bits 31:10 and 7:4 always read as zero.
- R2: Type codes are: 0 for nothing pending, 1 for buffer full, 2 for request lost and 3 for bus error. An empty line reads as the all-zero word.
- R3: Slot k is bit k of each flag set input (full_set, lost_set, berr_set), and its slot number is reported as k.
- R4: Line 1 considers only slots whose line_map bit is 1. Line 0 considers only slots whose line_map bit is 0.
- R5: Among the pending mapped flags, the lowest slot number wins. Within one slot, bus error wins over request lost, which wins over buffer full.
- R6: irq_line[l] is high exactly while line l has a nonzero type code.
- R7: A read with rd_be[0] set and dbg_mode low clears the reported flag on the clock edge that accepts the read. The next read then returns the next pending interrupt. A read never clears more than one flag.
- R8: While dbg_mode is high, a read leaves every flag unchanged.
- R9: Each byte lane whose rd_be bit is low returns zeros. A read with rd_be[0] low clears nothing. A read of byte 0 alone still clears the flag. A half-word read (rd_be = 4'b0011) returns type and slot together.
- R10: A set pulse wins over a read-clear of the same bit in the same cycle: the flag stays set.
- R11: After reset, all flags are clear, irq_line is 0, and rd_data and rd_valid are 0.
- R12: rd_valid is high in the cycle after each accepted read. rd_data then holds the word as it was in the accepting cycle, and keeps it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| full_set | input | NSLOT | Buffer-full set pulses, one per slot |
| lost_set | input | NSLOT | Request-lost set pulses, one per slot |
| berr_set | input | NSLOT | Bus-error set pulses, one per slot |
| line_map | input | NSLOT | Per-slot line select (1 = line 1) |
| dbg_mode | input | 1 | Debug: reads do not clear flags |
| rd_en | input | 1 | Read request, accepted in the same cycle |
| rd_sel | input | 1 | Line whose offset word is read |
| rd_be | input | 4 | Byte lane enables of the read |
| rd_data | output | 32 | Captured offset word |
| rd_valid | output | 1 | rd_data updated by the last cycle's read |
| irq_line | output | 2 | Interrupt line outputs |

## Verification
The bench first sweeps every slot, every flag type and both lines, one flag at a time. This shows that the slot numbering, the type code and the line routing are independent of each other, and that a read clears only its own flag. Dense patterns with many flags across all three banks and a mixed map are then drained one read at a time and compared against an arithmetic priority model. This separates slot order from type order within a slot. Finally, targeted reads cover three cases. Debug reads and byte-lane subsets show when the clear side effect fires. A set pulse that coincides with a clear of the same bit shows that the set takes precedence.

// File: rtl/irqv_pkg.sv
`timescale 1ns/1ps
package irqv_pkg;

   localparam int NSRC         = 3;
   localparam int SLOT_FIELD_W = 4;
   localparam int TYPE_LSB     = 8;
   localparam int WORD_W       = 32;
   localparam int NLINE        = 2;

   // bank index; type code equals index + 1
   localparam int SRC_FULL = 0;
   localparam int SRC_LOST = 1;
   localparam int SRC_BERR = 2;

   typedef enum logic [1:0] {
      IRQT_NONE = 2'd0,
      IRQT_FULL = 2'd1,
      IRQT_LOST = 2'd2,
      IRQT_BERR = 2'd3
   } irq_type_e;

   typedef struct packed {
      logic                    vld;
      irq_type_e               typ;
      logic [SLOT_FIELD_W-1:0] slot;
   } cand_t;

   function automatic logic [WORD_W-1:0] pack_word(input cand_t c);
      logic [WORD_W-1:0] w;
      w = '0;
      if (c.vld) begin
         w[TYPE_LSB +: 2]        = c.typ;
         w[0 +: SLOT_FIELD_W]    = c.slot;
      end
      return w;
   endfunction

endpackage

// File: rtl/irqv_flag_bank.sv
`timescale 1ns/1ps
module irqv_flag_bank
   import irqv_pkg::*;
#(
   parameter int NSLOT = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NSRC-1:0][NSLOT-1:0]  set_i,
   input  logic [NSRC-1:0][NSLOT-1:0]  clr_i,
   output logic [NSRC-1:0][NSLOT-1:0]  flag_o
);

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_o[s] <= '0;
         end else begin
            // a set pulse overrides a simultaneous clear
            flag_o[s] <= set_i[s] | (flag_o[s] & ~clr_i[s]);
         end
      end
   end

endmodule

// File: rtl/irqv_prio_enc.sv
`timescale 1ns/1ps
module irqv_prio_enc
   import irqv_pkg::*;
#(
   parameter int NSLOT    = 16,
   parameter bit TREE_ENC = 1'b1
) (
   input  logic [NSRC-1:0][NSLOT-1:0] flag_i,
   input  logic [NSLOT-1:0]           mask_i,
   output cand_t                      win_o
);

   cand_t leaf [NSLOT];

   always_comb begin
      for (int k = 0; k < NSLOT; k++) begin
         leaf[k].slot = SLOT_FIELD_W'(k);
         leaf[k].vld  = mask_i[k] &
                        (flag_i[SRC_FULL][k] | flag_i[SRC_LOST][k] | flag_i[SRC_BERR][k]);
         if (flag_i[SRC_BERR][k])      leaf[k].typ = IRQT_BERR;
         else if (flag_i[SRC_LOST][k]) leaf[k].typ = IRQT_LOST;
         else if (flag_i[SRC_FULL][k]) leaf[k].typ = IRQT_FULL;
         else                          leaf[k].typ = IRQT_NONE;
      end
   end

   if (TREE_ENC) begin : g_tree
      // heap layout: node 1 is the root, leaves sit at NSLOT..2*NSLOT-1
      cand_t node [2*NSLOT];
      assign node[0] = '0;
      for (genvar k = 0; k < NSLOT; k++) begin : g_leaf
         assign node[NSLOT+k] = leaf[k];
      end
      for (genvar i = 1; i < NSLOT; i++) begin : g_node
         // left child holds the lower slots and wins when valid
         assign node[i] = node[2*i].vld ? node[2*i] : node[2*i+1];
      end
      assign win_o = node[1];
   end else begin : g_scan
      always_comb begin
         win_o = '0;
         for (int k = NSLOT-1; k >= 0; k--) begin
            if (leaf[k].vld) win_o = leaf[k];
         end
      end
   end

endmodule

// File: rtl/irqv_rd_port.sv
`timescale 1ns/1ps
module irqv_rd_port
   import irqv_pkg::*;
#(
   parameter int NSLOT = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rd_en,
   input  logic                        rd_sel,
   input  logic [WORD_W/8-1:0]         rd_be,
   input  logic                        dbg_mode,
   input  cand_t                       win_i [NLINE],
   output logic [WORD_W-1:0]           rd_data,
   output logic                        rd_valid,
   output logic [NSRC-1:0][NSLOT-1:0]  clr_o
);

   localparam int SLOT_W = $clog2(NSLOT);
   localparam int NBYTE  = WORD_W / 8;

   cand_t              sel_c;
   logic [WORD_W-1:0]  word_full;
   logic [WORD_W-1:0]  word_lane;
   logic [1:0]         src_idx;
   logic               fire;

   assign sel_c     = win_i[rd_sel];
   assign word_full = pack_word(sel_c);

   for (genvar b = 0; b < NBYTE; b++) begin : g_lane
      assign word_lane[8*b +: 8] = rd_be[b] ? word_full[8*b +: 8] : 8'h00;
   end

   // the slot field lives in byte 0; only a read covering it has the side effect
   assign fire    = rd_en & rd_be[0] & ~dbg_mode & sel_c.vld;
   assign src_idx = sel_c.typ - 2'd1;

   always_comb begin
      clr_o = '0;
      if (fire) clr_o[src_idx][sel_c.slot[SLOT_W-1:0]] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= word_lane;
      end
   end

endmodule

// File: rtl/irq_offset_vec.sv
`timescale 1ns/1ps
module irq_offset_vec
   import irqv_pkg::*;
#(
   parameter int NSLOT    = 16,
   parameter bit TREE_ENC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSLOT-1:0]  full_set,
   input  logic [NSLOT-1:0]  lost_set,
   input  logic [NSLOT-1:0]  berr_set,
   input  logic [NSLOT-1:0]  line_map,
   input  logic              dbg_mode,
   input  logic              rd_en,
   input  logic              rd_sel,
   input  logic [3:0]        rd_be,
   output logic [31:0]       rd_data,
   output logic              rd_valid,
   output logic [1:0]        irq_line
);

   if (NSLOT < 2 || NSLOT > (1 << SLOT_FIELD_W) || (NSLOT & (NSLOT - 1)) != 0) begin : g_bad_nslot
      $error("irq_offset_vec: NSLOT must be a power of two from 2 to %0d", 1 << SLOT_FIELD_W);
   end
   if (WORD_W != 32) begin : g_bad_word
      $error("irq_offset_vec: word width must be 32");
   end

   logic [NSRC-1:0][NSLOT-1:0] set_all;
   logic [NSRC-1:0][NSLOT-1:0] clr_all;
   logic [NSRC-1:0][NSLOT-1:0] flag_q;
   cand_t                      win [NLINE];

   assign set_all[SRC_FULL] = full_set;
   assign set_all[SRC_LOST] = lost_set;
   assign set_all[SRC_BERR] = berr_set;

   irqv_flag_bank #(.NSLOT(NSLOT)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_all),
      .clr_i  (clr_all),
      .flag_o (flag_q)
   );

   for (genvar l = 0; l < NLINE; l++) begin : g_line
      logic [NSLOT-1:0] mask;
      assign mask = (l == 1) ? line_map : ~line_map;
      irqv_prio_enc #(.NSLOT(NSLOT), .TREE_ENC(TREE_ENC)) u_enc (
         .flag_i (flag_q),
         .mask_i (mask),
         .win_o  (win[l])
      );
      assign irq_line[l] = win[l].vld;
   end

   irqv_rd_port #(.NSLOT(NSLOT)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .rd_sel   (rd_sel),
      .rd_be    (rd_be),
      .dbg_mode (dbg_mode),
      .win_i    (win),
      .rd_data  (rd_data),
      .rd_valid (rd_valid),
      .clr_o    (clr_all)
   );

endmodule

// File: rtl/irqv_chk.sv
`timescale 1ns/1ps
module irqv_chk
   import irqv_pkg::*;
#(
   parameter int NSLOT = 16
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        rd_en,
   input logic [3:0]                  rd_be,
   input logic                        dbg_mode,
   input logic [31:0]                 rd_data,
   input logic                        rd_valid,
   input logic [1:0]                  irq_line,
   input logic [NSRC-1:0][NSLOT-1:0]  flags,
   input logic [NSRC-1:0][NSLOT-1:0]  sets
);

   // R1
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_data[31:10] == '0 && rd_data[7:4] == '0));

   // R12
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   // R12
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   // R6
   quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == '0) |-> (irq_line == 2'b00));

   // R8
   dbg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && dbg_mode) |=> (($past(flags) & ~flags) == '0));

   // R7
   one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> ($countones($past(flags) & ~flags) <= 1));

   // R7
   no_read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (($past(flags) & ~flags) == '0));

   // R9
   lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_be[0]) |=> (($past(flags) & ~flags) == '0));

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sets != '0) |=> (($past(sets) & ~flags) == '0));

endmodule

bind irq_offset_vec irqv_chk #(.NSLOT(NSLOT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en    (rd_en),
   .rd_be    (rd_be),
   .dbg_mode (dbg_mode),
   .rd_data  (rd_data),
   .rd_valid (rd_valid),
   .irq_line (irq_line),
   .flags    (flag_q),
   .sets     (set_all)
);

// File: tb/sim_irq_offset_vec.sv
`timescale 1ns/1ps
module sim_irq_offset_vec;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] full_set = '0, lost_set = '0, berr_set = '0, line_map = '0;
   logic        dbg_mode = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
   logic [3:0]  rd_be = 4'hF;
   logic [31:0] rd_data;
   logic        rd_valid;
   logic [1:0]  irq_line;

   int checks = 0;
   int errors = 0;

   logic [15:0] m_full = '0, m_lost = '0, m_berr = '0;

   always #10 clk = ~clk;

   irq_offset_vec #(.NSLOT(16), .TREE_ENC(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .full_set(full_set), .lost_set(lost_set),
      .berr_set(berr_set), .line_map(line_map), .dbg_mode(dbg_mode),
      .rd_en(rd_en), .rd_sel(rd_sel), .rd_be(rd_be), .rd_data(rd_data),
      .rd_valid(rd_valid), .irq_line(irq_line));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // model: lowest slot first, then bus error > lost > full
   function automatic logic [31:0] calc(input int line);
      for (int k = 0; k < 16; k++) begin
         if (line_map[k] == line[0]) begin
            if (m_berr[k]) return 32'h300 | k;
            if (m_lost[k]) return 32'h200 | k;
            if (m_full[k]) return 32'h100 | k;
         end
      end
      return 32'h0;
   endfunction

   function automatic logic [31:0] lanes(input logic [3:0] be);
      return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

   task automatic chk_irq(input string req);
      logic [1:0] e;
      e = {calc(1)[9:8] != 2'd0, calc(0)[9:8] != 2'd0};
      chk(req, {30'd0, irq_line}, {30'd0, e});
   endtask

   task automatic pulse(input logic [15:0] f, input logic [15:0] l, input logic [15:0] b);
      @(negedge clk);
      full_set = f; lost_set = l; berr_set = b;
      @(negedge clk);
      full_set = '0; lost_set = '0; berr_set = '0;
      m_full |= f; m_lost |= l; m_berr |= b;
   endtask

   task automatic rd(input string req, input bit sel, input logic [3:0] be, input bit dbg,
                     input logic [15:0] cset, output logic [31:0] got);
      logic [31:0] full_w;
      @(negedge clk);
      full_w = calc(int'(sel));
      rd_en = 1'b1; rd_sel = sel; rd_be = be; dbg_mode = dbg; full_set = cset;
      @(negedge clk);
      rd_en = 1'b0; dbg_mode = 1'b0; full_set = '0; rd_be = 4'hF;
      got = rd_data;
      chk(req, rd_data, full_w & lanes(be));
      chk({req, " valid"}, {31'd0, rd_valid}, 32'd1);
      if (be[0] && !dbg && full_w[9:8] != 2'd0) begin
         case (full_w[9:8])
            2'd1: m_full[full_w[3:0]] = 1'b0;
            2'd2: m_lost[full_w[3:0]] = 1'b0;
            default: m_berr[full_w[3:0]] = 1'b0;
         endcase
      end
      m_full |= cset;
   endtask

   task automatic drain(input string req, input bit sel);
      logic [31:0] got;
      for (int n = 0; n < 60; n++) begin
         rd(req, sel, 4'hF, 1'b0, '0, got);
         chk_irq("R6 drain");
         if (got[9:8] == 2'd0) break;
      end
   endtask

   initial begin
      #4_000_000;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] got;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 rd_data", rd_data, 32'h0);
      chk("R11 rd_valid", {31'd0, rd_valid}, 32'd0);
      chk("R11 irq", {30'd0, irq_line}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 irq after release", {30'd0, irq_line}, 32'd0);
      rd("R2 empty line0", 1'b0, 4'hF, 1'b0, '0, got);

      // R3 R2 R4 sweep: one flag at a time, every slot, type and line
      for (int k = 0; k < 16; k++) begin
         for (int s = 0; s < 3; s++) begin
            for (int l = 0; l < 2; l++) begin
               @(negedge clk);
               line_map = (l == 1) ? (16'h1 << k) : 16'h0;
               pulse(s == 0 ? (16'h1 << k) : '0, s == 1 ? (16'h1 << k) : '0,
                     s == 2 ? (16'h1 << k) : '0);
               chk_irq("R6 single");
               rd("R4 other line empty", l == 0, 4'hF, 1'b0, '0, got);
               rd("R3 R2 single word", l[0], 4'hF, 1'b0, '0, got);
               chk("R3 slot", {28'd0, got[3:0]}, k);
               chk("R7 cleared", {30'd0, irq_line}, 32'd0);
            end
         end
      end

      // R5 priority drain with dense patterns
      @(negedge clk); line_map = 16'h3C3C;
      pulse(16'hF0F0, 16'h0FF0, 16'h8421);
      chk_irq("R6 dense");
      drain("R5 dense line0", 1'b0);
      drain("R5 dense line1", 1'b1);
      @(negedge clk); line_map = 16'h0000;
      pulse(16'h0220, 16'h0020, 16'h0020);
      drain("R5 same slot order", 1'b0);

      // R8 debug reads leave flags alone
      pulse('0, 16'h0008, '0);
      rd("R8 debug read 1", 1'b0, 4'hF, 1'b1, '0, got);
      rd("R8 debug read 2", 1'b0, 4'hF, 1'b1, '0, got);
      chk("R8 word kept", got, 32'h203);
      rd("R7 normal read", 1'b0, 4'hF, 1'b0, '0, got);
      rd("R7 next empty", 1'b0, 4'hF, 1'b0, '0, got);

      // R9 byte lanes
      pulse('0, '0, 16'h0080);
      rd("R9 type byte only", 1'b0, 4'b0010, 1'b0, '0, got);
      rd("R9 upper half", 1'b0, 4'b1100, 1'b0, '0, got);
      rd("R9 half word", 1'b0, 4'b0011, 1'b1, '0, got);
      chk("R9 half word value", got, 32'h307);
      rd("R9 slot byte clears", 1'b0, 4'b0001, 1'b0, '0, got);
      rd("R9 empty after byte", 1'b0, 4'hF, 1'b0, '0, got);

      // R10 set pulse collides with clear
      pulse(16'h0004, '0, '0);
      rd("R10 read with set", 1'b0, 4'hF, 1'b0, 16'h0004, got);
      chk_irq("R10 still pending");
      rd("R10 flag kept", 1'b0, 4'hF, 1'b0, '0, got);
      chk("R10 word", got, 32'h102);
      rd("R10 then empty", 1'b0, 4'hF, 1'b0, '0, got);

      // R12 data held between reads
      repeat (2) @(negedge clk);
      chk("R12 valid low idle", {31'd0, rd_valid}, 32'd0);
      chk("R12 data held", rd_data, 32'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule